// File: doc/BRIEF.md
# Vectored Interrupt Message Controller

This block gathers a parameterised set of interrupt lines (64 by default) and turns each active one into a single-beat message carrying an 8-bit vector and an 8-bit route byte. Every line is first brought into the clock domain through two flops. Software then chooses for each line whether it is sensed by level or by edge, and which polarity counts as active. Lines that are pending, not masked and allowed to generate messages take turns on the output. A round-robin pointer decides the order.

Software configures the block through a 32-bit register bus with per-byte write enables. Read data is combinational from the address. The per-source configuration bits are packed 32 to a word, and source n sits in word n/32 at bit n%32. The vector and route tables hold one byte per source. A read-only identification word reports how many sources the block has. The message port is a valid/ready handshake. Once a message is offered, it stays unchanged until it is taken.

Top module: `vecirq_ctrl`

## Requirements
- R1: After reset, msg_valid is low. Both mask words read 0xFFFFFFFF. The edge, polarity, message-enable, auxiliary, route and vector registers all read zero.
- R2: The word at byte offset 0x04 holds the source count minus one in bits 23:16, so it reads 0x003F0000 with 64 sources. The word at 0x00 reads zero.
- R3: The configuration words are mask (0x20), message enable (0x40), edge (0x60), polarity (0x3E0) and two auxiliary words (0xC0, 0xE0). Each has one word per 32 sources, 4 bytes apart, and source n is at bit n%32 of word n/32. A write changes byte lane k only when bus_be[k] is 1. The auxiliary words read back what was written and affect nothing else.
- R4: The route byte of source n is at 0x100+n and its vector byte is at 0x200+n. Each is bits 8*(n%4)+7 down to 8*(n%4) of the aligned word.
- R5: A source with edge bit 0 is pending while its synchronised input is at the active level: high when its polarity bit is 0, low when it is 1. It is offered again after each completed handshake for as long as it stays active.
- R6: A source with edge bit 1 latches pending on a rising transition (polarity 0) or a falling transition (polarity 1). Each latch yields one message. No further message follows until the latch is cleared and a new transition occurs.
- R7: Writing 1 to a bit of the clear words (0x80) drops the latched pending state of that edge source. A 0 bit leaves it unchanged, and the clear words read zero.
- R8: A message is produced only for a source whose mask bit is 0 and whose message-enable bit is 1.
- R9: When several sources are eligible, they are granted in increasing index order, with wrap-around, starting just after the last granted source.
- R10: While msg_valid is high and msg_ready is low, msg_valid stays high and msg_vector and msg_route hold. The message carries the vector and route bytes of the granted source.
- R11: Reads of unmapped offsets return zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 64 | Asynchronous interrupt lines |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address (bits 1:0 ignored) |
| bus_be | input | 4 | Byte write enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Message accepted by the downstream side |
| msg_vector | output | 8 | Vector of the offered message |
| msg_route | output | 8 | Route byte of the offered message |

## Verification
The assertions check four properties on every cycle. The offered message holds steady until it is accepted. A newly raised message always belongs to a source that was unmasked and enabled on the cycle it was chosen. The identification, clear and unmapped offsets always read their fixed values. Reset always leaves the output idle. Only the bench scenarios can show the sensing behaviour and the grant order: level re-offers, one message per edge latch, the effect of clear bits, polarity inversion, and the rotation of grants among several active lines.

// File: rtl/vecirq_pkg.sv
package vecirq_pkg;

    // Word addresses (byte offset / 4) of the register regions
    localparam logic [9:0] W_ID    = 10'h000;  // 0x000
    localparam logic [9:0] W_MASK  = 10'h008;  // 0x020
    localparam logic [9:0] W_MSGEN = 10'h010;  // 0x040
    localparam logic [9:0] W_EDGE  = 10'h018;  // 0x060
    localparam logic [9:0] W_CLR   = 10'h020;  // 0x080
    localparam logic [9:0] W_AUXA  = 10'h030;  // 0x0C0
    localparam logic [9:0] W_AUXB  = 10'h038;  // 0x0E0
    localparam logic [9:0] W_ROUTE = 10'h040;  // 0x100
    localparam logic [9:0] W_VEC   = 10'h080;  // 0x200
    localparam logic [9:0] W_POL   = 10'h0F8;  // 0x3E0

    typedef enum logic [3:0] {
        RS_NONE, RS_ID, RS_MASK, RS_MSGEN, RS_EDGE, RS_CLR,
        RS_AUXA, RS_AUXB, RS_ROUTE, RS_VEC, RS_POL
    } regsel_e;

    typedef struct packed {
        logic [7:0] vector;
        logic [7:0] route;
    } msg_t;

    function automatic logic in_span(logic [9:0] word, logic [9:0] base, int unsigned span);
        return (32'(word) >= 32'(base)) && (32'(word) < 32'(base) + span);
    endfunction

    function automatic logic [31:0] be_mask(logic [3:0] be);
        logic [31:0] m;
        for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{be[i]}};
        return m;
    endfunction

    function automatic logic [31:0] merge_bytes(logic [31:0] old, logic [31:0] wd, logic [3:0] be);
        return (old & ~be_mask(be)) | (wd & be_mask(be));
    endfunction

endpackage

// File: rtl/vecirq_regfile.sv
module vecirq_regfile
    import vecirq_pkg::*;
#(
    parameter int unsigned N_SRC = 64
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_sel,
    input  logic                  bus_we,
    input  logic [11:0]           bus_addr,
    input  logic [3:0]            bus_be,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    output logic [N_SRC-1:0]      mask_o,
    output logic [N_SRC-1:0]      en_o,
    output logic [N_SRC-1:0]      edge_o,
    output logic [N_SRC-1:0]      pol_o,
    output logic [N_SRC-1:0]      clr_o,
    output logic [N_SRC-1:0][7:0] route_o,
    output logic [N_SRC-1:0][7:0] vec_o
);
    localparam int unsigned NW = N_SRC / 32;
    localparam int unsigned NT = N_SRC / 4;
    localparam int unsigned BW = (NW > 1) ? $clog2(NW) : 1;
    localparam int unsigned TW = $clog2(NT);

    logic [NW-1:0][31:0] mask_q, en_q, edge_q, pol_q, auxa_q, auxb_q;
    logic [NT-1:0][31:0] route_q, vec_q;

    logic [9:0]    word;
    logic          addr_unused;
    regsel_e       sel;
    logic [BW-1:0] bidx;
    logic [TW-1:0] tidx;
    logic          wr_en;

    assign word        = bus_addr[11:2];
    assign addr_unused = ^bus_addr[1:0];
    assign bidx        = word[BW-1:0];
    assign tidx        = word[TW-1:0];
    assign wr_en       = bus_sel && bus_we;

    always_comb begin
        sel = RS_NONE;
        if      (in_span(word, W_ID, 2))     sel = RS_ID;
        else if (in_span(word, W_MASK, NW))  sel = RS_MASK;
        else if (in_span(word, W_MSGEN, NW)) sel = RS_MSGEN;
        else if (in_span(word, W_EDGE, NW))  sel = RS_EDGE;
        else if (in_span(word, W_CLR, NW))   sel = RS_CLR;
        else if (in_span(word, W_AUXA, NW))  sel = RS_AUXA;
        else if (in_span(word, W_AUXB, NW))  sel = RS_AUXB;
        else if (in_span(word, W_ROUTE, NT)) sel = RS_ROUTE;
        else if (in_span(word, W_VEC, NT))   sel = RS_VEC;
        else if (in_span(word, W_POL, NW))   sel = RS_POL;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= '1;
            en_q    <= '0;
            edge_q  <= '0;
            pol_q   <= '0;
            auxa_q  <= '0;
            auxb_q  <= '0;
            route_q <= '0;
            vec_q   <= '0;
        end else if (wr_en) begin
            case (sel)
                RS_MASK:  mask_q[bidx]  <= merge_bytes(mask_q[bidx], bus_wdata, bus_be);
                RS_MSGEN: en_q[bidx]    <= merge_bytes(en_q[bidx], bus_wdata, bus_be);
                RS_EDGE:  edge_q[bidx]  <= merge_bytes(edge_q[bidx], bus_wdata, bus_be);
                RS_POL:   pol_q[bidx]   <= merge_bytes(pol_q[bidx], bus_wdata, bus_be);
                RS_AUXA:  auxa_q[bidx]  <= merge_bytes(auxa_q[bidx], bus_wdata, bus_be);
                RS_AUXB:  auxb_q[bidx]  <= merge_bytes(auxb_q[bidx], bus_wdata, bus_be);
                RS_ROUTE: route_q[tidx] <= merge_bytes(route_q[tidx], bus_wdata, bus_be);
                RS_VEC:   vec_q[tidx]   <= merge_bytes(vec_q[tidx], bus_wdata, bus_be);
                default: ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            RS_ID:    bus_rdata = word[0] ? (32'(N_SRC - 1) << 16) : 32'h0;
            RS_MASK:  bus_rdata = mask_q[bidx];
            RS_MSGEN: bus_rdata = en_q[bidx];
            RS_EDGE:  bus_rdata = edge_q[bidx];
            RS_POL:   bus_rdata = pol_q[bidx];
            RS_AUXA:  bus_rdata = auxa_q[bidx];
            RS_AUXB:  bus_rdata = auxb_q[bidx];
            RS_ROUTE: bus_rdata = route_q[tidx];
            RS_VEC:   bus_rdata = vec_q[tidx];
            default:  bus_rdata = 32'h0;
        endcase
    end

    for (genvar b = 0; b < NW; b++) begin : g_clr
        assign clr_o[b*32 +: 32] = (wr_en && sel == RS_CLR && bidx == BW'(b))
                                   ? (bus_wdata & be_mask(bus_be)) : 32'h0;
    end

    assign mask_o  = mask_q;
    assign en_o    = en_q;
    assign edge_o  = edge_q;
    assign pol_o   = pol_q;
    assign route_o = route_q;
    assign vec_o   = vec_q;

endmodule

// File: rtl/vecirq_front.sv
module vecirq_front #(
    parameter int unsigned N_SRC = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] irq_i,
    input  logic [N_SRC-1:0] edge_i,
    input  logic [N_SRC-1:0] pol_i,
    input  logic [N_SRC-1:0] clr_i,
    input  logic [N_SRC-1:0] sent_i,
    output logic [N_SRC-1:0] req_o
);
    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        logic s1_q, s2_q, prev_q, pend_q, served_q;
        logic act, det, pend_kept;

        assign act       = s2_q ^ pol_i[g];
        assign det       = act && !prev_q;
        assign pend_kept = pend_q && !clr_i[g];

        always_ff @(posedge clk) begin
            if (rst) begin
                s1_q     <= 1'b0;
                s2_q     <= 1'b0;
                prev_q   <= 1'b0;
                pend_q   <= 1'b0;
                served_q <= 1'b0;
            end else begin
                s1_q   <= irq_i[g];
                s2_q   <= s1_q;
                prev_q <= act;
                pend_q <= pend_kept || (det && edge_i[g]);
                if (det && edge_i[g] && !pend_kept)
                    served_q <= 1'b0;
                else if (sent_i[g] && edge_i[g])
                    served_q <= 1'b1;
            end
        end

        assign req_o[g] = edge_i[g] ? (pend_q && !served_q) : act;
    end

endmodule

// File: rtl/vecirq_rr.sv
module vecirq_rr #(
    parameter int unsigned N_SRC = 64,
    parameter int unsigned IW    = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0] req_i,
    input  logic [IW-1:0]    last_i,
    output logic             found_o,
    output logic [IW-1:0]    pick_o
);
    always_comb begin
        found_o = 1'b0;
        pick_o  = '0;
        for (int k = 1; k <= int'(N_SRC); k++) begin
            if (!found_o && req_i[(int'(last_i) + k) % int'(N_SRC)]) begin
                found_o = 1'b1;
                pick_o  = IW'((int'(last_i) + k) % int'(N_SRC));
            end
        end
    end

endmodule

// File: rtl/vecirq_ctrl.sv
module vecirq_ctrl
    import vecirq_pkg::*;
#(
    parameter int unsigned N_SRC = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] irq_in,
    input  logic             bus_sel,
    input  logic             bus_we,
    input  logic [11:0]      bus_addr,
    input  logic [3:0]       bus_be,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    output logic             msg_valid,
    input  logic             msg_ready,
    output logic [7:0]       msg_vector,
    output logic [7:0]       msg_route
);
    localparam int unsigned IW = $clog2(N_SRC);

    logic [N_SRC-1:0]      mask_w, en_w, edge_w, pol_w, clr_w, req_w, elig_w, sent_w;
    logic [N_SRC-1:0][7:0] route_w, vec_w;
    logic                  found_w;
    logic [IW-1:0]         pick_w, last_q, cur_src;
    logic                  valid_q;
    msg_t                  msg_q;

    vecirq_regfile #(.N_SRC(N_SRC)) u_regs (
        .clk(clk), .rst(rst),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mask_o(mask_w), .en_o(en_w), .edge_o(edge_w), .pol_o(pol_w),
        .clr_o(clr_w), .route_o(route_w), .vec_o(vec_w)
    );

    vecirq_front #(.N_SRC(N_SRC)) u_front (
        .clk(clk), .rst(rst), .irq_i(irq_in), .edge_i(edge_w),
        .pol_i(pol_w), .clr_i(clr_w), .sent_i(sent_w), .req_o(req_w)
    );

    assign elig_w = req_w & ~mask_w & en_w;

    vecirq_rr #(.N_SRC(N_SRC), .IW(IW)) u_rr (
        .req_i(elig_w), .last_i(last_q), .found_o(found_w), .pick_o(pick_w)
    );

    always_comb begin
        sent_w = '0;
        if (valid_q && msg_ready) sent_w[cur_src] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            last_q  <= '1;
            cur_src <= '0;
            msg_q   <= '0;
        end else if (valid_q) begin
            if (msg_ready) valid_q <= 1'b0;
        end else if (found_w) begin
            valid_q      <= 1'b1;
            cur_src      <= pick_w;
            last_q       <= pick_w;
            msg_q.vector <= vec_w[pick_w];
            msg_q.route  <= route_w[pick_w];
        end
    end

    assign msg_valid  = valid_q;
    assign msg_vector = msg_q.vector;
    assign msg_route  = msg_q.route;

endmodule

// File: rtl/vecirq_ctrl_chk.sv
module vecirq_ctrl_chk #(
    parameter int unsigned N_SRC = 64,
    parameter int unsigned IW    = $clog2(N_SRC)
) (
    input logic             clk,
    input logic             rst,
    input logic             msg_valid,
    input logic             msg_ready,
    input logic [7:0]       msg_vector,
    input logic [7:0]       msg_route,
    input logic [11:0]      bus_addr,
    input logic [31:0]      bus_rdata,
    input logic [N_SRC-1:0] mask_cfg,
    input logic [N_SRC-1:0] en_cfg,
    input logic [IW-1:0]    cur_src
);
    logic [N_SRC-1:0] mask_d, en_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_d <= '1;
            en_d   <= '0;
        end else begin
            mask_d <= mask_cfg;
            en_d   <= en_cfg;
        end
    end

    // R10
    msg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vector) && $stable(msg_route)));

    // R1
    reset_idle_chk: assert property (@(posedge clk) rst |=> !msg_valid);

    // R8
    eligible_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(msg_valid) |-> (en_d[cur_src] && !mask_d[cur_src]));

    // R2
    id_word_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[11:2] == 10'd1) |-> (bus_rdata == (32'(N_SRC - 1) << 16)));

    // R7
    clr_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[11:3] == 9'h010) |-> (bus_rdata == 32'h0));

    // R11
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[11:10] != 2'b00) |-> (bus_rdata == 32'h0));

endmodule

bind vecirq_ctrl vecirq_ctrl_chk #(.N_SRC(N_SRC)) u_chk (
    .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_vector(msg_vector), .msg_route(msg_route), .bus_addr(bus_addr),
    .bus_rdata(bus_rdata), .mask_cfg(mask_w), .en_cfg(en_w), .cur_src(cur_src)
);

// File: tb/vecirq_ctrl_tb.sv
module vecirq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] irq_in = '0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        msg_valid, msg_ready = 1'b0;
    logic [7:0]  msg_vector, msg_route;

    int nchk = 0;
    int nfail = 0;

    always #10 clk = ~clk;

    vecirq_ctrl u_dut (
        .clk(clk), .rst(rst), .irq_in(irq_in), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector), .msg_route(msg_route)
    );

    // {write, requirement number, address, byte enables, data or expected read}
    localparam int NROWS = 23;
    localparam logic [52:0] TBL [NROWS] = '{
        {1'b0, 4'd1,  12'h020, 4'hF, 32'hFFFF_FFFF},  // R1 mask word 0
        {1'b0, 4'd1,  12'h024, 4'hF, 32'hFFFF_FFFF},  // R1 mask word 1
        {1'b0, 4'd1,  12'h060, 4'hF, 32'h0000_0000},  // R1 edge
        {1'b0, 4'd1,  12'h3E4, 4'hF, 32'h0000_0000},  // R1 polarity
        {1'b0, 4'd2,  12'h004, 4'hF, 32'h003F_0000},  // R2 id high word
        {1'b0, 4'd2,  12'h000, 4'hF, 32'h0000_0000},  // R2 id low word
        {1'b1, 4'd3,  12'h040, 4'hF, 32'hA5A5_0F0F},
        {1'b0, 4'd3,  12'h040, 4'hF, 32'hA5A5_0F0F},  // R3 full write
        {1'b1, 4'd3,  12'h040, 4'h2, 32'h1234_5678},
        {1'b0, 4'd3,  12'h040, 4'hF, 32'hA5A5_560F},  // R3 lane 1 only
        {1'b1, 4'd3,  12'h0C4, 4'hF, 32'hDEAD_BEEF},
        {1'b0, 4'd3,  12'h0C4, 4'hF, 32'hDEAD_BEEF},  // R3 aux readback
        {1'b1, 4'd3,  12'h0E0, 4'h9, 32'h1122_3344},
        {1'b0, 4'd3,  12'h0E0, 4'hF, 32'h1100_0044},  // R3 lanes 0 and 3
        {1'b1, 4'd4,  12'h104, 4'h8, 32'h7700_0000},
        {1'b0, 4'd4,  12'h104, 4'hF, 32'h7700_0000},  // R4 route of source 7
        {1'b1, 4'd7,  12'h080, 4'hF, 32'hFFFF_FFFF},
        {1'b0, 4'd7,  12'h080, 4'hF, 32'h0000_0000},  // R7 clear reads zero
        {1'b1, 4'd11, 12'h010, 4'hF, 32'h0000_1234},
        {1'b0, 4'd11, 12'h010, 4'hF, 32'h0000_0000},  // R11 unmapped
        {1'b0, 4'd11, 12'h500, 4'hF, 32'h0000_0000},  // R11 high unmapped
        {1'b1, 4'd3,  12'h040, 4'hF, 32'h0000_0000},
        {1'b0, 4'd3,  12'h040, 4'hF, 32'h0000_0000}   // R3 restore
    };

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [3:0] be, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd_chk(string tag, logic [11:0] a, logic [31:0] exp);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #2;
        check(tag, bus_rdata, exp);
        bus_sel = 1'b0;
    endtask

    task automatic wait_msg(output bit got);
        got = 1'b0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk); #1;
            if (msg_valid) begin got = 1'b1; break; end
        end
    endtask

    task automatic quiet(string tag, int n);
        bit seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
            if (msg_valid) seen = 1'b1;
        end
        check(tag, 32'(seen), 32'd0);
    endtask

    task automatic accept();
        @(negedge clk); msg_ready = 1'b1;
        @(negedge clk); msg_ready = 1'b0;
    endtask

    task automatic drain();
        @(negedge clk); msg_ready = 1'b1;
        repeat (8) @(negedge clk);
        msg_ready = 1'b0;
    endtask

    task automatic pulse_line(int n, bit lvl);
        irq_in[n] = !lvl;
        repeat (4) @(negedge clk);
        irq_in[n] = lvl;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        bit got;
        logic [7:0] seq [6];

        repeat (3) @(negedge clk);
        #1 check("R1 valid in reset", 32'(msg_valid), 32'd0);
        rst = 1'b0;
        @(negedge clk); #1 check("R1 valid after reset", 32'(msg_valid), 32'd0);

        for (int r = 0; r < NROWS; r++) begin
            if (TBL[r][52]) wr(TBL[r][47:36], TBL[r][35:32], TBL[r][31:0]);
            else rd_chk($sformatf("R%0d row %0d", TBL[r][51:48], r), TBL[r][47:36], TBL[r][31:0]);
        end

        // R5 level-high source 5, vector 0x45, route 0x11
        wr(12'h204, 4'h2, 32'h0000_4500);
        wr(12'h104, 4'h2, 32'h0000_1100);
        wr(12'h040, 4'hF, 32'h0000_0020);
        wr(12'h020, 4'hF, 32'hFFFF_FFDF);
        irq_in[5] = 1'b1;
        wait_msg(got);
        check("R5 level high offered", 32'(got), 32'd1);
        check("R10 vector of source 5", 32'(msg_vector), 32'h45);
        check("R10 route of source 5", 32'(msg_route), 32'h11);
        repeat (3) @(negedge clk);
        #1 check("R10 held while not ready", {msg_valid, msg_vector}, {1'b1, 8'h45});
        accept();
        wait_msg(got);
        check("R5 re-offered while active", {7'd0, got, msg_vector}, {8'd1, 8'h45});
        irq_in[5] = 1'b0;
        repeat (6) @(negedge clk);
        drain();
        quiet("R5 inactive level silent", 10);
        wr(12'h020, 4'hF, 32'hFFFF_FFFF);

        // R5 level-low source 6, vector 0x66
        irq_in[6] = 1'b1;
        wr(12'h204, 4'h4, 32'h0066_0000);
        wr(12'h3E0, 4'hF, 32'h0000_0040);
        wr(12'h040, 4'hF, 32'h0000_0040);
        wr(12'h020, 4'hF, 32'hFFFF_FFBF);
        quiet("R5 active-low input high is idle", 8);
        irq_in[6] = 1'b0;
        wait_msg(got);
        check("R5 active-low offered", {7'd0, got, msg_vector}, {8'd1, 8'h66});
        irq_in[6] = 1'b1;
        repeat (6) @(negedge clk);
        drain();
        wr(12'h020, 4'hF, 32'hFFFF_FFFF);
        wr(12'h040, 4'hF, 32'h0000_0000);

        // R8 source 40: unmasked but not enabled, then enabled, then masked
        wr(12'h024, 4'hF, 32'hFFFF_FEFF);
        irq_in[40] = 1'b1;
        quiet("R8 disabled source silent", 10);
        wr(12'h044, 4'hF, 32'h0000_0100);
        wait_msg(got);
        check("R8 enabled source offered", 32'(got), 32'd1);
        wr(12'h024, 4'hF, 32'hFFFF_FFFF);
        accept();
        quiet("R8 masked source silent", 10);
        irq_in[40] = 1'b0;
        wr(12'h044, 4'hF, 32'h0000_0000);

        // R6 rising edge on source 33, vector 0x21
        wr(12'h220, 4'h2, 32'h0000_2100);
        wr(12'h064, 4'hF, 32'h0000_0002);
        wr(12'h044, 4'hF, 32'h0000_0002);
        wr(12'h024, 4'hF, 32'hFFFF_FFFD);
        quiet("R6 no edge yet", 5);
        irq_in[33] = 1'b1;
        wait_msg(got);
        check("R6 rising edge offered", {7'd0, got, msg_vector}, {8'd1, 8'h21});
        accept();
        quiet("R6 single message per edge", 10);
        pulse_line(33, 1'b1);
        quiet("R6 no resend before clear", 6);
        wr(12'h084, 4'hF, 32'h0000_0002);
        quiet("R7 clear alone does not resend", 6);
        pulse_line(33, 1'b1);
        wait_msg(got);
        check("R6 retrigger after clear", {7'd0, got, msg_vector}, {8'd1, 8'h21});
        accept();
        // R7 zero bits leave latch alone
        wr(12'h024, 4'hF, 32'hFFFF_FFFF);
        wr(12'h084, 4'hF, 32'h0000_0002);
        pulse_line(33, 1'b1);
        wr(12'h084, 4'hF, 32'hFFFF_FFFD);
        wr(12'h024, 4'hF, 32'hFFFF_FFFD);
        wait_msg(got);
        check("R7 zero clear bit keeps pending", 32'(got), 32'd1);
        accept();
        // R7 one bit drops the latch
        wr(12'h024, 4'hF, 32'hFFFF_FFFF);
        wr(12'h084, 4'hF, 32'h0000_0002);
        pulse_line(33, 1'b1);
        wr(12'h084, 4'hF, 32'h0000_0002);
        wr(12'h024, 4'hF, 32'hFFFF_FFFD);
        quiet("R7 cleared latch not offered", 10);
        wr(12'h024, 4'hF, 32'hFFFF_FFFF);

        // R6 falling edge on source 34, vector 0x22
        irq_in[34] = 1'b1;
        repeat (4) @(negedge clk);
        wr(12'h220, 4'h4, 32'h0022_0000);
        wr(12'h3E4, 4'hF, 32'h0000_0004);
        wr(12'h064, 4'hF, 32'h0000_0004);
        wr(12'h044, 4'hF, 32'h0000_0004);
        wr(12'h024, 4'hF, 32'hFFFF_FFFB);
        quiet("R6 falling source idle while high", 6);
        irq_in[34] = 1'b0;
        wait_msg(got);
        check("R6 falling edge offered", {7'd0, got, msg_vector}, {8'd1, 8'h22});
        accept();
        wr(12'h024, 4'hF, 32'hFFFF_FFFF);
        wr(12'h044, 4'hF, 32'h0000_0000);

        // R9 round robin among level sources 1, 2, 3 with vectors 1, 2, 3
        wr(12'h200, 4'hE, 32'h0302_0100);
        wr(12'h040, 4'hF, 32'h0000_000E);
        irq_in[1] = 1'b1; irq_in[2] = 1'b1; irq_in[3] = 1'b1;
        repeat (4) @(negedge clk);
        wr(12'h020, 4'hF, 32'hFFFF_FFF1);
        for (int i = 0; i < 6; i++) begin
            wait_msg(got);
            seq[i] = got ? msg_vector : 8'hFF;
            accept();
        end
        check("R9 first grant in set", 32'((seq[0] >= 8'd1) && (seq[0] <= 8'd3)), 32'd1);
        for (int i = 1; i < 6; i++)
            check($sformatf("R9 grant %0d follows", i), 32'(seq[i]),
                  32'((seq[i-1] == 8'd3) ? 8'd1 : seq[i-1] + 8'd1));

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule